// File: doc/BRIEF.md
# Jump Trace Buffer

This block predicts the target of a taken branch from the fetch address alone. It is a small, fully associative store of (source address, destination address) pairs. Every fetch address is compared against all occupied slots in the same cycle. A match means "taken", and the stored destination comes back with it. No match means "fall through". Nothing else is kept: there is no direction counter, and there is no confidence state.

The fetch unit records a taken branch through the insert port. A branch whose source address is already held is refused. Otherwise the pair goes into the slot named by a rotating allocation pointer, so the oldest surviving pair is the one overwritten. A wrong prediction never edits or removes a pair. Addresses are virtual, so the operating system's context switch drives the flush input, which empties the store at once.

Top module: `jump_trace_buf`

## Requirements
- R1: After reset no slot is occupied, so every lookup reports not taken.
- R2: A lookup whose address equals the source address of an occupied slot drives `pred_taken` high and `pred_target` to that slot's stored destination, in the same cycle (combinational).
- R3: A lookup that matches no occupied slot drives `pred_taken` low and `pred_target` to all zeros.
- R4: A pair accepted at a clock edge is not seen by lookups in the cycle it is presented, and is seen from the cycle after that edge.
- R5: An insert whose source address already sits in an occupied slot is refused. The stored destination stays unchanged, and the allocation pointer does not move.
- R6: Each accepted insert writes the slot at the allocation pointer and then advances the pointer by one, wrapping modulo DEPTH. With the store full, a new pair therefore evicts the oldest pair still present.
- R7: Lookups never alter stored state. Slot contents and the pointer change only through an accepted insert or a flush.
- R8: A flush empties every slot and returns the allocation pointer to slot 0. From the next cycle every lookup misses until new pairs are inserted.
- R9: When flush and insert are asserted in the same cycle, the flush takes effect and the insert is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| look_pc | input | ADDR_W | Fetch address to look up |
| pred_taken | output | 1 | High when look_pc matches an occupied slot |
| pred_target | output | ADDR_W | Stored destination on a match, zero otherwise |
| ins_valid | input | 1 | Request to record a taken branch |
| ins_from | input | ADDR_W | Source address of the branch to record |
| ins_to | input | ADDR_W | Destination address of the branch to record |
| flush | input | 1 | Empty the store (context switch) |

## Verification
The bench aims at four edges of this block.

- **Insert timing.** A lookup is made in the very cycle of its own insert, and must miss then and hit one cycle later. A design that forwards the write would hit too early.
- **Duplicate refusal.** A re-insert of a held address carries a different destination. The bench then fills the rest of the store. A design that overwrote the destination would return the wrong target. A design that advanced its pointer on the refusal would evict the first pair too soon.
- **FIFO eviction.** Overfilling by one pair, and then by two, must evict exactly the two oldest pairs in order.
- **Flush races.** A flush presented together with an insert must leave both the old and the new pair missing. A design that let the insert win would show a hit afterwards.

// File: rtl/jtb_pkg.sv
package jtb_pkg;

   function automatic bit jtb_is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction

   function automatic int jtb_ptr_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/jtb_slot.sv
module jtb_slot #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              we,
   input  logic [ADDR_W-1:0] wr_from,
   input  logic [ADDR_W-1:0] wr_to,
   input  logic [ADDR_W-1:0] look_pc,
   input  logic [ADDR_W-1:0] chk_pc,
   output logic              vld,
   output logic              look_hit,
   output logic              chk_hit,
   output logic [ADDR_W-1:0] tgt
);

   logic              vld_q;
   logic [ADDR_W-1:0] from_q;
   logic [ADDR_W-1:0] to_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         from_q <= '0;
         to_q   <= '0;
      end else if (clr) begin
         vld_q  <= 1'b0;
      end else if (we) begin
         vld_q  <= 1'b1;
         from_q <= wr_from;
         to_q   <= wr_to;
      end
   end

   assign vld      = vld_q;
   assign look_hit = vld_q && (from_q == look_pc);
   assign chk_hit  = vld_q && (from_q == chk_pc);
   assign tgt      = to_q;

endmodule

// File: rtl/jtb_fifo_ptr.sv
module jtb_fifo_ptr
   import jtb_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int PTR_W = jtb_ptr_w(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   output logic [PTR_W-1:0] ptr,
   output logic [DEPTH-1:0] sel
);

   logic [PTR_W-1:0] ptr_q;
   logic [PTR_W-1:0] ptr_nxt;

   generate
      if (jtb_is_pow2(DEPTH)) begin : g_wrap_free
         assign ptr_nxt = ptr_q + 1'b1;
      end else begin : g_wrap_cmp
         assign ptr_nxt = (ptr_q == PTR_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ptr_q <= '0;
      else if (clr)    ptr_q <= '0;
      else if (adv)    ptr_q <= ptr_nxt;
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_dec
      assign sel[i] = (ptr_q == PTR_W'(i));
   end

   assign ptr = ptr_q;

endmodule

// File: rtl/jtb_hit_mux.sv
module jtb_hit_mux #(
   parameter int ADDR_W = 32,
   parameter int DEPTH  = 8
) (
   input  logic [DEPTH-1:0]        hit,
   input  logic [DEPTH*ADDR_W-1:0] tgt_flat,
   output logic                    any_hit,
   output logic [ADDR_W-1:0]       target
);

   always_comb begin
      target = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (hit[i]) target = target | tgt_flat[i*ADDR_W +: ADDR_W];
      end
   end

   assign any_hit = |hit;

endmodule

// File: rtl/jump_trace_buf.sv
module jump_trace_buf
   import jtb_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DEPTH  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] look_pc,
   output logic              pred_taken,
   output logic [ADDR_W-1:0] pred_target,
   input  logic              ins_valid,
   input  logic [ADDR_W-1:0] ins_from,
   input  logic [ADDR_W-1:0] ins_to,
   input  logic              flush
);

   localparam int PTR_W = jtb_ptr_w(DEPTH);

   generate
      if (DEPTH < 2)  begin : g_bad_depth $error("jump_trace_buf: DEPTH must be at least 2"); end
      if (ADDR_W < 1) begin : g_bad_addr  $error("jump_trace_buf: ADDR_W must be positive"); end
   endgenerate

   logic [DEPTH-1:0]        valid_q;
   logic [DEPTH-1:0]        look_hit;
   logic [DEPTH-1:0]        dup_hit;
   logic [DEPTH-1:0]        slot_sel;
   logic [DEPTH-1:0]        slot_we;
   logic [DEPTH*ADDR_W-1:0] tgt_flat;
   logic [PTR_W-1:0]        wr_ptr;
   logic                    accept;

   assign accept  = ins_valid && !flush && !(|dup_hit);
   assign slot_we = slot_sel & {DEPTH{accept}};

   jtb_fifo_ptr #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (flush),
      .adv   (accept),
      .ptr   (wr_ptr),
      .sel   (slot_sel)
   );

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      jtb_slot #(.ADDR_W(ADDR_W)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr      (flush),
         .we       (slot_we[i]),
         .wr_from  (ins_from),
         .wr_to    (ins_to),
         .look_pc  (look_pc),
         .chk_pc   (ins_from),
         .vld      (valid_q[i]),
         .look_hit (look_hit[i]),
         .chk_hit  (dup_hit[i]),
         .tgt      (tgt_flat[i*ADDR_W +: ADDR_W])
      );
   end

   jtb_hit_mux #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_mux (
      .hit      (look_hit),
      .tgt_flat (tgt_flat),
      .any_hit  (pred_taken),
      .target   (pred_target)
   );

endmodule

// File: rtl/jtb_chk.sv
module jtb_chk #(
   parameter int ADDR_W = 32,
   parameter int DEPTH  = 8,
   parameter int PTR_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flush,
   input logic              ins_valid,
   input logic              pred_taken,
   input logic [ADDR_W-1:0] pred_target,
   input logic [DEPTH-1:0]  valid_q,
   input logic [PTR_W-1:0]  wr_ptr
);

   // R1
   empty_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q == '0) |-> !pred_taken);

   // R3
   miss_zero_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pred_taken |-> (pred_target == '0));

   // R8
   flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (valid_q == '0) && (wr_ptr == '0));

   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ins_valid && !flush) |=> $stable(valid_q) && $stable(wr_ptr));

   // R6
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flush |=> (wr_ptr == $past(wr_ptr)) ||
                 (wr_ptr == PTR_W'((int'($past(wr_ptr)) + 1) % DEPTH)));

   // R6
   fill_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flush |=> ($countones(valid_q) >= $past($countones(valid_q))));

endmodule

bind jump_trace_buf jtb_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_jtb_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .flush       (flush),
   .ins_valid   (ins_valid),
   .pred_taken  (pred_taken),
   .pred_target (pred_target),
   .valid_q     (valid_q),
   .wr_ptr      (wr_ptr)
);

// File: tb/tb_jump_trace_buf.sv
`timescale 1ns/1ps
module tb_jump_trace_buf;

   localparam int AW = 32;
   localparam int D  = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] look_pc = '0;
   logic          pred_taken;
   logic [AW-1:0] pred_target;
   logic          ins_valid = 1'b0;
   logic [AW-1:0] ins_from = '0;
   logic [AW-1:0] ins_to = '0;
   logic          flush = 1'b0;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   jump_trace_buf #(.ADDR_W(AW), .DEPTH(D)) dut (
      .clk(clk), .rst_n(rst_n), .look_pc(look_pc), .pred_taken(pred_taken),
      .pred_target(pred_target), .ins_valid(ins_valid), .ins_from(ins_from),
      .ins_to(ins_to), .flush(flush)
   );

   function automatic logic [AW-1:0] src(input int i);
      return 32'h0000_1000 + i * 4;
   endfunction

   function automatic logic [AW-1:0] dst(input int i);
      return 32'h0008_0000 + i * 16;
   endfunction

   task automatic probe(input logic [AW-1:0] a, input logic exp_t,
                        input logic [AW-1:0] exp_tgt, input string req);
      look_pc = a;
      #1;
      total++;
      if (pred_taken !== exp_t || pred_target !== exp_tgt) begin
         bad++;
         $display("FAIL %s addr=%h got taken=%b tgt=%h exp taken=%b tgt=%h",
                  req, a, pred_taken, pred_target, exp_t, exp_tgt);
      end
   endtask

   task automatic do_insert(input logic [AW-1:0] f, input logic [AW-1:0] t);
      @(negedge clk);
      ins_valid = 1'b1; ins_from = f; ins_to = t;
      @(negedge clk);
      ins_valid = 1'b0;
   endtask

   task automatic do_flush();
      @(negedge clk);
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
   endtask

   task automatic t_reset();
      for (int i = 0; i < 4; i++) probe(src(i), 1'b0, '0, "R1");
      probe(32'h0, 1'b0, '0, "R1");
   endtask

   task automatic t_hit_latency();
      do_flush();
      @(negedge clk);
      ins_valid = 1'b1; ins_from = src(3); ins_to = dst(3);
      probe(src(3), 1'b0, '0, "R4 same cycle");
      @(negedge clk);
      ins_valid = 1'b0;
      probe(src(3), 1'b1, dst(3), "R4 next cycle");
      probe(src(3), 1'b1, dst(3), "R2");
      probe(src(4), 1'b0, '0, "R3");
      probe(src(3) + 1, 1'b0, '0, "R3 near address");
   endtask

   task automatic t_dup();
      do_flush();
      do_insert(src(10), dst(10));
      do_insert(src(10), 32'hDEAD_BEE0);
      probe(src(10), 1'b1, dst(10), "R5 target kept");
      for (int i = 11; i < 18; i++) do_insert(src(i), dst(i));
      probe(src(10), 1'b1, dst(10), "R5 no slot consumed");
      probe(src(17), 1'b1, dst(17), "R5 last");
   endtask

   task automatic t_fifo();
      do_flush();
      for (int i = 0; i < D; i++) do_insert(src(20 + i), dst(20 + i));
      for (int i = 0; i < D; i++) probe(src(20 + i), 1'b1, dst(20 + i), "R6 full");
      do_insert(src(40), dst(40));
      probe(src(20), 1'b0, '0, "R6 oldest evicted");
      probe(src(21), 1'b1, dst(21), "R6 second kept");
      probe(src(40), 1'b1, dst(40), "R6 new present");
      do_insert(src(41), dst(41));
      probe(src(21), 1'b0, '0, "R6 second evicted");
      probe(src(22), 1'b1, dst(22), "R6 third kept");
   endtask

   task automatic t_persist();
      do_flush();
      do_insert(src(50), dst(50));
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         probe(src(50), 1'b1, dst(50), "R7 stable");
         probe(src(51), 1'b0, '0, "R7 miss stays miss");
      end
   endtask

   task automatic t_flush();
      do_flush();
      for (int i = 0; i < 3; i++) do_insert(src(60 + i), dst(60 + i));
      do_flush();
      for (int i = 0; i < 3; i++) probe(src(60 + i), 1'b0, '0, "R8");
      for (int i = 0; i < D; i++) do_insert(src(70 + i), dst(70 + i));
      for (int i = 0; i < D; i++) probe(src(70 + i), 1'b1, dst(70 + i), "R8 refill");
   endtask

   task automatic t_flush_wins();
      do_flush();
      do_insert(src(80), dst(80));
      @(negedge clk);
      flush = 1'b1; ins_valid = 1'b1; ins_from = src(81); ins_to = dst(81);
      @(negedge clk);
      flush = 1'b0; ins_valid = 1'b0;
      probe(src(81), 1'b0, '0, "R9 insert dropped");
      probe(src(80), 1'b0, '0, "R9 old cleared");
      do_insert(src(81), dst(81));
      probe(src(81), 1'b1, dst(81), "R9 later insert");
   endtask

   initial begin
      #(8 * 200000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_hit_latency();
      t_dup();
      t_fifo();
      t_persist();
      t_flush();
      t_flush_wins();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule